// File: doc/BRIEF.md
# Serial-to-NAND Bridge Command Engine

This block sits between a serial host link and a parallel NAND flash device. The host opens a frame by pulling chip select low and sends a command byte first. The engine then acts on the bytes that follow. One command streams data bytes onto the NAND bus. One loads a single control byte. Two return bytes fetched from the NAND bus, and they differ only in how many idle slots come before the data. The control byte drives the NAND chip enable, command latch and address latch lines, together with a fan enable and four active-low indicator outputs. The host therefore steers the NAND cycle type and the indicators through the same opcode set it uses for data.

The serial clock idles high. The host changes its data lines while the clock is low, and both sides sample on the rising edge. The clock and data pins are synchronised into the system clock domain, so each clock phase must last at least 12 system clocks. Data bytes of the write command travel two bits per clock on two host data lines. All other traffic uses one line. The engine makes its NAND strobes from the system clock and waits for each slot's first falling edge before it acts. A frame that ends after its last rising edge therefore never sets off a NAND cycle that the host did not ask for.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the control byte is 0x8F: chip enable inactive (high), command and address latch low, fan off, all four indicator outputs high. Both NAND strobes are high, the data bus is not driven and the serial output is low.
- R2: Every frame begins with the command byte, sent on the primary line one bit per rising clock edge, most significant bit first. Raising chip select abandons the frame at any point, and the next frame starts again with a command byte.
- R3: Opcode 0x09 copies the next byte into the control byte. Any later bytes of that frame leave it unchanged.
- R4: Control byte fields: bit 7 drives the NAND chip enable (active low), bit 6 the command latch, bit 5 the address latch, bit 4 the fan enable, and bits 3..0 the indicator outputs led_n[3:0] directly.
- R5: After opcode 0x08, each byte slot takes four clocks. Each rising edge takes one bit from the primary line and the next lower bit from the second line, so the bits arrive in the pairs (7,6), (5,4), (3,2), (1,0).
- R6: A byte received after opcode 0x08 is written to NAND at the first falling clock edge of the following slot. The host closes a write with one extra slot. If the frame ends without that slot, the last byte is not written.
- R7: In the slot that follows each data byte of opcode 0x08, the serial output presents that byte's bits 7, 5, 3 and 1 at the slot's four rising edges.
- R8: After opcode 0x0A, one idle slot returns zero. Every later slot returns one byte freshly read from NAND, most significant bit first, ready at the first rising edge. Each such slot issues exactly one read strobe, and no strobe is issued when the frame ends.
- R9: After opcode 0x0B, four idle slots return zero, and the slots that follow return NAND bytes as in R8.
- R10: Any other opcode makes the rest of the frame ignored: no NAND strobe and no change to the control byte.
- R11: For each write, the bus is driven one clock before the write strobe falls. The strobe stays low for PULSE_W (default 2) clocks, and the data stays driven for one clock after the strobe rises.
- R12: For each read, the read strobe stays low for PULSE_W clocks, the bus is sampled before the strobe rises, and the engine does not drive the bus during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Host chip select, active low |
| spi_sck | input | 1 | Host serial clock, idles high |
| spi_mosi | input | 1 | Primary host data line |
| spi_mosi2 | input | 1 | Second host data line (write data only) |
| spi_miso | output | 1 | Serial data to host |
| nand_dq_in | input | 8 | NAND bus value seen by the engine |
| nand_dq_out | output | 8 | NAND bus value driven by the engine |
| nand_dq_oe | output | 1 | Drive enable for nand_dq_out |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| fan_en | output | 1 | Fan enable |
| led_n | output | 4 | Indicator outputs, active low |

## Verification
A frame phase that was decoded wrongly shows up at the NAND strobes within one slot. It appears as a write or read strobe in an idle or ignored slot, or as a missing strobe where one was due, and the strobe counters catch this at the end of the frame. A bit counter that slips between single-line and dual-line mode corrupts the next received byte, so the write scoreboard sees the wrong data at the next write strobe. A stale read or echo register changes the MISO bits that the host samples in the same slot. A control byte that was loaded in error appears on the latch, fan and indicator pins as soon as the frame that loaded it ends.

// File: rtl/spi_nand_pkg.sv
package spi_nand_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WR_MULTI = 8'h08;
  localparam logic [BYTE_W-1:0] OP_WR_CTRL  = 8'h09;
  localparam logic [BYTE_W-1:0] OP_RD_MULTI = 8'h0A;
  localparam logic [BYTE_W-1:0] OP_RD_FAST  = 8'h0B;

  localparam int CB_CE_N = 7;
  localparam int CB_CLE  = 6;
  localparam int CB_ALE  = 5;
  localparam int CB_FAN  = 4;
  localparam int LED_N_W = 4;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_WDATA,
    PH_CTRL,
    PH_IDLE,
    PH_RDATA,
    PH_SINK
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WHOLD,
    ST_RLOW,
    ST_RREC
  } strobe_e;
endpackage

// File: rtl/spi_nand_sync.sv
module spi_nand_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_nand_shifter.sv
module spi_nand_shifter
  import spi_nand_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              mosi2,
  input  logic              dual_en,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              slot_start,
  output logic              frame_active,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;

  logic [3:0] raw_in, syn;
  logic cs_s, sck_s, mosi_s, mosi2_s, sck_q;
  logic rise, fall;
  logic [CNT_W-1:0] bit_cnt, cnt_nxt;
  logic [BYTE_W-1:0] rx_sr, sr_nxt, tx_sr;

  assign raw_in = {cs_n, sck, mosi, mosi2};

  spi_nand_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign {cs_s, sck_s, mosi_s, mosi2_s} = syn;
  assign frame_active = !cs_s;
  assign rise = frame_active && sck_s && !sck_q;
  assign fall = frame_active && !sck_s && sck_q;

  always_comb begin
    if (dual_en) begin
      sr_nxt  = {rx_sr[BYTE_W-3:0], mosi_s, mosi2_s};
      cnt_nxt = bit_cnt + CNT_W'(2);
    end else begin
      sr_nxt  = {rx_sr[BYTE_W-2:0], mosi_s};
      cnt_nxt = bit_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
    end
  end

  always_ff @(posedge clk) begin
    rx_valid   <= 1'b0;
    slot_start <= 1'b0;
    if (rst || !frame_active) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
      tx_sr   <= '0;
    end else begin
      if (rise) begin
        if (cnt_nxt == CNT_W'(BYTE_W)) begin
          bit_cnt  <= '0;
          rx_byte  <= sr_nxt;
          rx_valid <= 1'b1;
        end else begin
          bit_cnt <= cnt_nxt;
        end
        rx_sr <= sr_nxt;
      end
      if (fall && bit_cnt == '0) begin
        slot_start <= 1'b1;
      end
      if (tx_load) begin
        tx_sr <= tx_byte;
      end else if (fall && bit_cnt != '0) begin
        tx_sr <= dual_en ? {tx_sr[BYTE_W-3:0], 2'b00} : {tx_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sr[BYTE_W-1];

  // R5
  dual_align_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && dual_en) |-> (bit_cnt[0] == 1'b0));

  // R2
  no_edge_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_active |=> (bit_cnt == '0) && !rx_valid && !slot_start);
endmodule

// File: rtl/spi_nand_strobe.sv
module spi_nand_strobe
  import spi_nand_pkg::*;
#(
  parameter int PULSE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [BYTE_W-1:0] dq_in,
  output logic [BYTE_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              we_n,
  output logic              re_n,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_done,
  output logic              busy
);
  localparam int CNT_W = $clog2(PULSE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_W - 1);

  strobe_e st, st_nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE:  if (wr_req) st_nxt = ST_WSET;
                else if (rd_req) st_nxt = ST_RLOW;
      ST_WSET:  st_nxt = ST_WLOW;
      ST_WLOW:  if (cnt == LAST) st_nxt = ST_WHOLD;
      ST_WHOLD: st_nxt = ST_IDLE;
      ST_RLOW:  if (cnt == LAST) st_nxt = ST_RREC;
      ST_RREC:  st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    rd_done <= 1'b0;
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      rd_data <= '0;
    end else begin
      st    <= st_nxt;
      cnt   <= (st_nxt != st) ? '0 : cnt + CNT_W'(1);
      we_n  <= (st_nxt != ST_WLOW);
      re_n  <= (st_nxt != ST_RLOW);
      dq_oe <= (st_nxt == ST_WSET) || (st_nxt == ST_WLOW) || (st_nxt == ST_WHOLD);
      if (st == ST_IDLE && wr_req) dq_out <= wr_data;
      if (st == ST_RLOW && cnt == LAST) begin
        rd_data <= dq_in;
        rd_done <= 1'b1;
      end
    end
  end

  assign busy = (st != ST_IDLE);

  logic [CNT_W-1:0] wlen, rlen;
  always_ff @(posedge clk) begin
    if (rst) begin
      wlen <= '0;
      rlen <= '0;
    end else begin
      wlen <= we_n ? '0 : ((wlen == CNT_W'(PULSE_W)) ? wlen : wlen + CNT_W'(1));
      rlen <= re_n ? '0 : ((rlen == CNT_W'(PULSE_W)) ? rlen : rlen + CNT_W'(1));
    end
  end

  // R11
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (wlen >= CNT_W'(PULSE_W)));

  // R11
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (dq_oe && $stable(dq_out)));

  // R12
  re_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(re_n) |-> (rlen >= CNT_W'(PULSE_W)));

  // R12
  re_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> (!dq_oe && we_n));
endmodule

// File: rtl/spi_nand_ctrl.sv
module spi_nand_ctrl
  import spi_nand_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CTRL_RST = 8'h8F,
  parameter int MULTI_IDLE = 1,
  parameter int FAST_IDLE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              slot_start,
  input  logic              frame_active,
  input  logic              seq_busy,
  input  logic              rd_done,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              dual_en,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic [BYTE_W-1:0] ctrl_byte
);
  localparam int IDLE_W = $clog2(FAST_IDLE + 1);

  phase_e phase;
  logic [IDLE_W-1:0] idle_left;
  logic [BYTE_W-1:0] pend;
  logic pend_vld, rd_wait;

  always_ff @(posedge clk) begin
    tx_load <= 1'b0;
    wr_req  <= 1'b0;
    rd_req  <= 1'b0;
    if (rst) begin
      phase     <= PH_CMD;
      idle_left <= '0;
      pend      <= '0;
      pend_vld  <= 1'b0;
      rd_wait   <= 1'b0;
      tx_byte   <= '0;
      wr_data   <= '0;
      ctrl_byte <= CTRL_RST;
    end else if (!frame_active) begin
      phase    <= PH_CMD;
      pend_vld <= 1'b0;
      rd_wait  <= 1'b0;
    end else begin
      if (rx_valid) begin
        case (phase)
          PH_CMD: begin
            case (rx_byte)
              OP_WR_MULTI: phase <= PH_WDATA;
              OP_WR_CTRL:  phase <= PH_CTRL;
              OP_RD_MULTI: begin
                phase     <= PH_IDLE;
                idle_left <= IDLE_W'(MULTI_IDLE);
              end
              OP_RD_FAST: begin
                phase     <= PH_IDLE;
                idle_left <= IDLE_W'(FAST_IDLE);
              end
              default: phase <= PH_SINK;
            endcase
          end
          PH_WDATA: begin
            pend     <= rx_byte;
            pend_vld <= 1'b1;
          end
          PH_CTRL: begin
            ctrl_byte <= rx_byte;
            phase     <= PH_SINK;
          end
          PH_IDLE: begin
            idle_left <= idle_left - IDLE_W'(1);
            if (idle_left == IDLE_W'(1)) phase <= PH_RDATA;
          end
          default: ;
        endcase
      end
      if (slot_start) begin
        case (phase)
          PH_WDATA: begin
            tx_load <= 1'b1;
            tx_byte <= pend_vld ? pend : '0;
            if (pend_vld) begin
              wr_req  <= 1'b1;
              wr_data <= pend;
            end
          end
          PH_RDATA: begin
            rd_req  <= 1'b1;
            rd_wait <= 1'b1;
          end
          default: begin
            tx_load <= 1'b1;
            tx_byte <= '0;
          end
        endcase
      end
      if (rd_done && rd_wait) begin
        tx_load <= 1'b1;
        tx_byte <= rd_data;
        rd_wait <= 1'b0;
      end
    end
  end

  assign dual_en = (phase == PH_WDATA);

  // R2
  abort_to_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_active |=> (phase == PH_CMD));

  // R10
  sink_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SINK) |-> (!wr_req && !rd_req));

  // R8
  req_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req || rd_req) |-> !seq_busy);

  // R3
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_CTRL) |=> $stable(ctrl_byte));
endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
  import spi_nand_pkg::*;
#(
  parameter int PULSE_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] CTRL_RST = 8'h8F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  input  logic       spi_mosi2,
  output logic       spi_miso,
  input  logic [7:0] nand_dq_in,
  output logic [7:0] nand_dq_out,
  output logic       nand_dq_oe,
  output logic       nand_ce_n,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic       fan_en,
  output logic [3:0] led_n
);
  logic [BYTE_W-1:0] rx_byte, tx_byte, wr_data, rd_data, ctrl_byte;
  logic rx_valid, slot_start, frame_active, dual_en, tx_load;
  logic wr_req, rd_req, rd_done, seq_busy;

  spi_nand_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .mosi2(spi_mosi2), .dual_en(dual_en),
    .tx_load(tx_load), .tx_byte(tx_byte), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .slot_start(slot_start),
    .frame_active(frame_active), .miso(spi_miso)
  );

  spi_nand_ctrl #(.CTRL_RST(CTRL_RST)) u_ctrl (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .slot_start(slot_start), .frame_active(frame_active),
    .seq_busy(seq_busy), .rd_done(rd_done), .rd_data(rd_data),
    .dual_en(dual_en), .tx_load(tx_load), .tx_byte(tx_byte),
    .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
    .ctrl_byte(ctrl_byte)
  );

  spi_nand_strobe #(.PULSE_W(PULSE_W)) u_strobe (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(rd_req), .dq_in(nand_dq_in), .dq_out(nand_dq_out),
    .dq_oe(nand_dq_oe), .we_n(nand_we_n), .re_n(nand_re_n),
    .rd_data(rd_data), .rd_done(rd_done), .busy(seq_busy)
  );

  assign nand_ce_n = ctrl_byte[CB_CE_N];
  assign nand_cle  = ctrl_byte[CB_CLE];
  assign nand_ale  = ctrl_byte[CB_ALE];
  assign fan_en    = ctrl_byte[CB_FAN];
  assign led_n     = ctrl_byte[LED_N_W-1:0];

  // R1
  reset_ctrl_chk: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_byte == CTRL_RST && nand_we_n && nand_re_n && !nand_dq_oe));
endmodule

// File: tb/spi_nand_bridge_tb.sv
module spi_nand_bridge_tb;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1, spi_sck = 1'b1, spi_mosi = 1'b0, spi_mosi2 = 1'b0;
  logic spi_miso;
  logic [7:0] nand_dq_in, nand_dq_out;
  logic nand_dq_oe, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, fan_en;
  logic [3:0] led_n;

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int rptr = 0, wr_count = 0, rd_count = 0;
  bit done = 0;
  logic [10:0] wq [$];

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 5);
  endfunction

  assign nand_dq_in = nand_re_n ? 8'h00 : pat(rptr);

  spi_nand_bridge u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_mosi2(spi_mosi2), .spi_miso(spi_miso),
    .nand_dq_in(nand_dq_in), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .fan_en(fan_en), .led_n(led_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: write scoreboard and strobe widths
  int wlow = 0, rlow = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!nand_we_n) wlow++;
      if (!nand_re_n) begin
        rlow++;
        if (nand_dq_oe) begin errors++; checks++; $display("FAIL R12 actual=oe1 expected=oe0"); end
      end
      if (!prev_we && nand_we_n) begin
        wr_count++;
        chk(wlow >= 2, "R11 we width", wlow, 2);
        chk(nand_dq_oe == 1'b1, "R11 hold", nand_dq_oe, 1);
        if (wq.size() == 0) chk(0, "R6 unexpected write", {nand_ce_n, nand_cle, nand_ale, nand_dq_out}, 0);
        else begin
          logic [10:0] e;
          e = wq.pop_front();
          chk({nand_ce_n, nand_cle, nand_ale, nand_dq_out} == e, "R5/R6 write data", {nand_ce_n, nand_cle, nand_ale, nand_dq_out}, e);
        end
        wlow = 0;
      end
      if (!prev_re && nand_re_n) begin
        rd_count++;
        rptr++;
        chk(rlow >= 2, "R12 re width", rlow, 2);
        rlow = 0;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_on();
    spi_cs_n = 1'b0; wt(H);
  endtask

  task automatic cs_off();
    wt(H); spi_cs_n = 1'b1; spi_mosi = 0; spi_mosi2 = 0; wt(3 * H);
  endtask

  task automatic sbit(input logic b, output logic r);
    spi_sck = 1'b0; spi_mosi = b; spi_mosi2 = 1'b0; wt(H);
    r = spi_miso; spi_sck = 1'b1; wt(H);
  endtask

  task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) sbit(b[i], r[i]);
  endtask

  task automatic dbyte(input logic [7:0] b, output logic [3:0] r);
    for (int i = 0; i < 4; i++) begin
      spi_sck = 1'b0; spi_mosi = b[7-2*i]; spi_mosi2 = b[6-2*i]; wt(H);
      r[3-i] = spi_miso; spi_sck = 1'b1; wt(H);
    end
  endtask

  task automatic ctrl_frame(input logic [7:0] v);
    logic [7:0] r;
    cs_on(); sbyte(8'h09, r); sbyte(v, r); cs_off();
  endtask

  function automatic logic [3:0] odd_bits(logic [7:0] b);
    return {b[7], b[5], b[3], b[1]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r8;
    logic [3:0] r4;
    int wc0, rc0, p0;
    wt(5); rst = 1'b0; wt(2);

    // R1 reset state
    chk({nand_ce_n, nand_cle, nand_ale, fan_en, led_n} == 8'h8F, "R1 ctrl", {nand_ce_n, nand_cle, nand_ale, fan_en, led_n}, 8'h8F);
    chk({nand_we_n, nand_re_n, nand_dq_oe, spi_miso} == 4'b1100, "R1 strobes", {nand_we_n, nand_re_n, nand_dq_oe, spi_miso}, 4'b1100);

    // R3 R4 control write, extra bytes ignored
    cs_on(); sbyte(8'h09, r8); sbyte(8'h5A, r8); sbyte(8'hFF, r8); sbyte(8'h00, r8); cs_off();
    chk({nand_ce_n, nand_cle, nand_ale, fan_en} == 4'b0101, "R4 latch fields", {nand_ce_n, nand_cle, nand_ale, fan_en}, 4'b0101);
    chk(led_n == 4'hA, "R3/R4 led", led_n, 4'hA);

    // R5 R6 R7 dual-line write with trailing slot
    ctrl_frame(8'h2F);
    wc0 = wr_count;
    wq.push_back({3'b001, 8'h3C}); wq.push_back({3'b001, 8'hA5}); wq.push_back({3'b001, 8'h81});
    cs_on(); sbyte(8'h08, r8);
    dbyte(8'h3C, r4);
    chk(r4 == 4'h0, "R7 first slot", r4, 0);
    dbyte(8'hA5, r4);
    chk(r4 == odd_bits(8'h3C), "R7 echo 3C", r4, odd_bits(8'h3C));
    dbyte(8'h81, r4);
    chk(r4 == odd_bits(8'hA5), "R7 echo A5", r4, odd_bits(8'hA5));
    dbyte(8'h00, r4);
    chk(r4 == odd_bits(8'h81), "R7 echo 81", r4, odd_bits(8'h81));
    cs_off();
    chk(wr_count - wc0 == 3 && wq.size() == 0, "R6 write count", wr_count - wc0, 3);

    // R6 frame without trailing slot drops last byte
    wc0 = wr_count;
    wq.push_back({3'b001, 8'h11});
    cs_on(); sbyte(8'h08, r8); dbyte(8'h11, r4); dbyte(8'h22, r4); cs_off();
    chk(wr_count - wc0 == 1 && wq.size() == 0, "R6 no trailing", wr_count - wc0, 1);

    // R2 abort mid command byte, then new frame
    cs_on(); for (int i = 0; i < 4; i++) sbit(1'b1, r8[0]); cs_off();
    ctrl_frame(8'h8F);
    chk({nand_ce_n, nand_cle, nand_ale, fan_en, led_n} == 8'h8F, "R2 restart", {nand_ce_n, nand_cle, nand_ale, fan_en, led_n}, 8'h8F);

    // R8 read multiple
    rc0 = rd_count; p0 = rptr;
    cs_on(); sbyte(8'h0A, r8);
    sbyte(8'h00, r8);
    chk(r8 == 8'h00, "R8 idle slot", r8, 0);
    for (int k = 0; k < 3; k++) begin
      sbyte(8'h00, r8);
      chk(r8 == pat(p0 + k), "R8 read data", r8, pat(p0 + k));
    end
    cs_off();
    chk(rd_count - rc0 == 3, "R8 strobe count", rd_count - rc0, 3);

    // R9 fast read
    rc0 = rd_count; p0 = rptr;
    cs_on(); sbyte(8'h0B, r8);
    for (int k = 0; k < 4; k++) begin
      sbyte(8'h00, r8);
      chk(r8 == 8'h00 && rd_count == rc0, "R9 idle slot", r8, 0);
    end
    for (int k = 0; k < 2; k++) begin
      sbyte(8'h00, r8);
      chk(r8 == pat(p0 + k), "R9 read data", r8, pat(p0 + k));
    end
    cs_off();
    chk(rd_count - rc0 == 2, "R9 strobe count", rd_count - rc0, 2);

    // R10 unknown opcode
    wc0 = wr_count; rc0 = rd_count;
    cs_on(); sbyte(8'h55, r8); sbyte(8'h09, r8); sbyte(8'h00, r8); sbyte(8'h0A, r8); cs_off();
    chk(wr_count == wc0 && rd_count == rc0, "R10 no strobes", wr_count + rd_count, wc0 + rc0);
    chk({nand_ce_n, nand_cle, nand_ale, fan_en, led_n} == 8'h8F, "R10 ctrl kept", {nand_ce_n, nand_cle, nand_ale, fan_en, led_n}, 8'h8F);
    chk(wq.size() == 0, "R6 scoreboard drained", wq.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule